// File: doc/BRIEF.md
# Guarded Register File with Access Faults

This block is the architectural register storage of a 32-bit core. A 5-bit index selects each register. The block has two combinational read ports and one write port. Each index has its own access rule: an ordinary register, a register reserved for kernel mode, a constant zero, the program counter, or an index that no instruction may name. For every access the block returns the read data and raises a protection flag or an illegal-access flag in the same cycle. The core can then stop the instruction before anything is committed.

The storage holds 22 words. Indices 0x00 to 0x0F are sixteen general registers. Index 0x10 is the accumulator, 0x11 the stack pointer, 0x12 the frame base and 0x13 the link register. Indices 0x14 and 0x15 are two table-address registers reserved for kernel mode. Index 0x16 is a constant zero. Index 0x17 is a placeholder that must never be named. Index 0x1C shows the program counter. The core loads the program counter through its own load pins, which bypass the write-port rules. All pins are plain control and data pins with no handshake. The flags belong to the access presented in the current cycle, and a write commits at the next rising clock edge.

Top module: `rf_guarded_regs`

## Requirements
- R1: Indices 0x00–0x13 are ordinary registers. A write with `wr_en` high stores `wr_data` at the rising edge. The new value is visible on both read ports from the cycle after that edge. A read in the same cycle as the write returns the old value. Accesses to these indices never raise a flag.
- R2: Indices 0x14 and 0x15 behave like R1 when `kernel_mode` is 1. When `kernel_mode` is 0, an enabled read or write of either index raises `prot_fault`. In that mode a read returns 0 and a write leaves the register unchanged.
- R3: Index 0x16 always reads as 0. A write to it is dropped and raises no flag.
- R4: Index 0x17 raises `illegal_fault` on an enabled read or write. A read of it returns 0 and a write to it changes nothing.
- R5: Indices 0x18–0x1B and 0x1D–0x1F behave exactly like index 0x17.
- R6: Index 0x1C reads the current program counter in either mode. A write-port access to 0x1C raises `prot_fault` and leaves the program counter unchanged.
- R7: With `pc_load` high, the program counter takes `pc_next` at the rising edge. This happens in either mode, and also when the write port targets 0x1C in the same cycle.
- R8: The flags are combinational. Each flag is the OR of that flag over the enabled ports. A port whose enable is 0 contributes no flag, but its read data still follows R1–R6.
- R9: While `rst_n` is 0, every register and the program counter read 0 (`PC_RESET` defaults to 0). During reset, accesses are judged as kernel mode whatever `kernel_mode` says.
- R10: A write that raises a flag modifies no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_mode | input | 1 | 1 = kernel mode, 0 = user mode |
| rd_a_en | input | 1 | Read port A is in use this cycle |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_en | input | 1 | Read port B is in use this cycle |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write port request |
| wr_idx | input | 5 | Write port index |
| wr_data | input | DATA_W | Write port data |
| pc_load | input | 1 | Load the program counter at the next edge |
| pc_next | input | DATA_W | Value loaded into the program counter |
| prot_fault | output | 1 | Protection fault for the current access |
| illegal_fault | output | 1 | Illegal index for the current access |

## Verification
Read data and both flags are due in the same cycle that the inputs are applied. The bench drives each access on the falling edge and samples one nanosecond later, before the next rising edge. A write or program-counter load shows up one rising edge later. The bench updates its reference model only after that edge, so a read in the same cycle as a write is checked against the old value. Every index is swept in both modes, through both read ports and the write port. Reset is checked while `rst_n` is held low.

// File: rtl/rf_guard_pkg.sv
`timescale 1ns/1ps
package rf_guard_pkg;

  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IX_ACC  = 5'h10;
  localparam logic [IDX_W-1:0] IX_SP   = 5'h11;
  localparam logic [IDX_W-1:0] IX_BP   = 5'h12;
  localparam logic [IDX_W-1:0] IX_LINK = 5'h13;
  localparam logic [IDX_W-1:0] IX_TBL0 = 5'h14;
  localparam logic [IDX_W-1:0] IX_TBL1 = 5'h15;
  localparam logic [IDX_W-1:0] IX_ZERO = 5'h16;
  localparam logic [IDX_W-1:0] IX_VOID = 5'h17;
  localparam logic [IDX_W-1:0] IX_PC   = 5'h1C;

  // number of indices backed by storage (0x00 .. 0x15)
  localparam int N_SLOT = int'(IX_TBL1) + 1;

  typedef enum logic [2:0] {
    SLOT_PLAIN,
    SLOT_PRIV,
    SLOT_ZERO,
    SLOT_PC,
    SLOT_VOID
  } slot_kind_e;

  function automatic slot_kind_e classify(input logic [IDX_W-1:0] ix);
    slot_kind_e k;
    if (ix <= IX_LINK)                        k = SLOT_PLAIN;
    else if (ix == IX_TBL0 || ix == IX_TBL1)  k = SLOT_PRIV;
    else if (ix == IX_ZERO)                   k = SLOT_ZERO;
    else if (ix == IX_PC)                     k = SLOT_PC;
    else                                      k = SLOT_VOID;
    return k;
  endfunction

endpackage

// File: rtl/rf_port_check.sv
`timescale 1ns/1ps
module rf_port_check
  import rf_guard_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             en,
  input  logic             kernel,
  output logic             prot,
  output logic             illegal,
  output logic             pass
);
  slot_kind_e kind;
  logic       prot_hit;
  logic       void_hit;

  assign kind     = classify(idx);
  assign void_hit = (kind == SLOT_VOID);

  generate
    if (IS_WRITE) begin : g_wr
      // writes: table regs need kernel, PC never writable through this port
      assign prot_hit = ((kind == SLOT_PRIV) && !kernel) || (kind == SLOT_PC);
      // only storage-backed indices may commit; zero slot silently drops
      assign pass     = (kind == SLOT_PLAIN) || ((kind == SLOT_PRIV) && kernel);
    end else begin : g_rd
      assign prot_hit = (kind == SLOT_PRIV) && !kernel;
      // data shown unless the read would fault
      assign pass     = !(prot_hit || void_hit);
    end
  endgenerate

  assign prot    = en && prot_hit;
  assign illegal = en && void_hit;

endmodule

// File: rtl/rf_store.sv
`timescale 1ns/1ps
module rf_store
  import rf_guard_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              SLOTS    = 22,
  parameter int              RD_PORTS = 2,
  parameter logic [DATA_W-1:0] PC_RESET = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [IDX_W-1:0]                  widx,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              pc_load,
  input  logic [DATA_W-1:0]                 pc_next,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]    ridx,
  output logic [RD_PORTS-1:0][DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]                 pc_q
);
  localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(SLOTS - 1);

  logic [DATA_W-1:0] slot_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (we && widx == IDX_W'(s)) slot_q[s] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= PC_RESET;
    else if (pc_load) pc_q <= pc_next;
  end

  generate
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      always_comb begin
        if (ridx[p] <= SLOT_LAST)   rdata[p] = slot_q[ridx[p]];
        else if (ridx[p] == IX_PC)  rdata[p] = pc_q;
        else                        rdata[p] = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/rf_guarded_regs.sv
`timescale 1ns/1ps
module rf_guarded_regs
  import rf_guard_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kernel_mode,
  input  logic              rd_a_en,
  input  logic [4:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [4:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_load,
  input  logic [DATA_W-1:0] pc_next,
  output logic              prot_fault,
  output logic              illegal_fault
);
  localparam int RD_PORTS = 2;

  logic                            eff_kernel;
  logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx;
  logic [RD_PORTS-1:0]             rd_en;
  logic [RD_PORTS-1:0][DATA_W-1:0] rd_raw;
  logic [RD_PORTS-1:0]             rd_prot, rd_ill, rd_pass;
  logic                            wr_prot, wr_ill, wr_pass;
  logic [DATA_W-1:0]               pc_q;

  // reset forces kernel treatment
  assign eff_kernel = kernel_mode | ~rst_n;

  assign rd_idx = {rd_b_idx, rd_a_idx};
  assign rd_en  = {rd_b_en, rd_a_en};

  generate
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rchk
      rf_port_check #(.IS_WRITE(1'b0)) u_rchk (
        .idx     (rd_idx[p]),
        .en      (rd_en[p]),
        .kernel  (eff_kernel),
        .prot    (rd_prot[p]),
        .illegal (rd_ill[p]),
        .pass    (rd_pass[p])
      );
    end
  endgenerate

  rf_port_check #(.IS_WRITE(1'b1)) u_wchk (
    .idx     (wr_idx),
    .en      (wr_en),
    .kernel  (eff_kernel),
    .prot    (wr_prot),
    .illegal (wr_ill),
    .pass    (wr_pass)
  );

  rf_store #(
    .DATA_W   (DATA_W),
    .SLOTS    (N_SLOT),
    .RD_PORTS (RD_PORTS),
    .PC_RESET (PC_RESET)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en && wr_pass),
    .widx    (wr_idx),
    .wdata   (wr_data),
    .pc_load (pc_load),
    .pc_next (pc_next),
    .ridx    (rd_idx),
    .rdata   (rd_raw),
    .pc_q    (pc_q)
  );

  assign rd_a_data = rd_pass[0] ? rd_raw[0] : '0;
  assign rd_b_data = rd_pass[1] ? rd_raw[1] : '0;

  assign prot_fault    = (|rd_prot) | wr_prot;
  assign illegal_fault = (|rd_ill)  | wr_ill;

endmodule

// File: rtl/rf_guarded_regs_chk.sv
`timescale 1ns/1ps
module rf_guarded_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kernel_mode,
  input logic              rd_a_en,
  input logic [4:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              rd_b_en,
  input logic [4:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [4:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              pc_load,
  input logic [DATA_W-1:0] pc_next,
  input logic              prot_fault,
  input logic              illegal_fault,
  input logic [DATA_W-1:0] pc_q
);

  // R1
  plain_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 5'h14) |=>
      ((rd_a_idx == $past(wr_idx)) |-> (rd_a_data == $past(wr_data))));

  // R2
  user_table_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_en && !kernel_mode && (rd_a_idx == 5'h14 || rd_a_idx == 5'h15))
      |-> (prot_fault && rd_a_data == '0));

  // R3
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'h16) |-> (rd_b_data == '0));

  // R3
  zero_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 5'h16 && !rd_a_en && !rd_b_en)
      |-> (!prot_fault && !illegal_fault));

  // R5
  void_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_en && rd_a_idx[4:3] == 2'b11 && rd_a_idx != 5'h1C) |-> illegal_fault);

  // R6
  pc_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 5'h1C && !pc_load) |=> (pc_q == $past(pc_q)));

  // R7
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (pc_q == $past(pc_next)));

endmodule

bind rf_guarded_regs rf_guarded_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .kernel_mode   (kernel_mode),
  .rd_a_en       (rd_a_en),
  .rd_a_idx      (rd_a_idx),
  .rd_a_data     (rd_a_data),
  .rd_b_en       (rd_b_en),
  .rd_b_idx      (rd_b_idx),
  .rd_b_data     (rd_b_data),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_data       (wr_data),
  .pc_load       (pc_load),
  .pc_next       (pc_next),
  .prot_fault    (prot_fault),
  .illegal_fault (illegal_fault),
  .pc_q          (pc_q)
);

// File: tb/tb_rf_guarded_regs.sv
`timescale 1ns/1ps
module tb_rf_guarded_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kernel_mode = 1'b0;
  logic        rd_a_en = 1'b0, rd_b_en = 1'b0, wr_en = 1'b0, pc_load = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] wr_data = '0, pc_next = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        prot_fault, illegal_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [31:0] m [22];
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  rf_guarded_regs dut (
    .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_load(pc_load), .pc_next(pc_next),
    .prot_fault(prot_fault), .illegal_fault(illegal_fault)
  );

  function automatic bit e_prot(int ix, bit wr, bit kern);
    return ((ix == 20 || ix == 21) && !kern) || (wr && ix == 28);
  endfunction

  function automatic bit e_ill(int ix);
    return (ix == 23) || (ix >= 24 && ix != 28);
  endfunction

  function automatic string req_of(int ix);
    if (ix < 20)       return "R1";
    else if (ix < 22)  return "R2";
    else if (ix == 22) return "R3";
    else if (ix == 23) return "R4";
    else if (ix == 28) return "R6";
    else               return "R5";
  endfunction

  function automatic logic [31:0] e_data(int ix, bit kern);
    if (e_prot(ix, 1'b0, kern) || e_ill(ix)) return '0;
    if (ix < 22)  return m[ix];
    if (ix == 28) return m_pc;
    return '0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input int ra, input bit rae, input int rb, input bit rbe,
                      input int wi, input bit we, input logic [31:0] wd,
                      input bit kern, input bit pcl, input logic [31:0] pcn,
                      input string req);
    bit ep, ei;
    @(negedge clk);
    rd_a_idx = 5'(ra); rd_a_en = rae;
    rd_b_idx = 5'(rb); rd_b_en = rbe;
    wr_idx = 5'(wi); wr_en = we; wr_data = wd;
    kernel_mode = kern; pc_load = pcl; pc_next = pcn;
    #1;
    ep = (rae && e_prot(ra, 1'b0, kern)) || (rbe && e_prot(rb, 1'b0, kern)) ||
         (we && e_prot(wi, 1'b1, kern));
    ei = (rae && e_ill(ra)) || (rbe && e_ill(rb)) || (we && e_ill(wi));
    chk(req, "port A data", rd_a_data, e_data(ra, kern));
    chk(req, "port B data", rd_b_data, e_data(rb, kern));
    chk({req, " R8"}, "prot_fault", 32'(prot_fault), 32'(ep));
    chk({req, " R8"}, "illegal_fault", 32'(illegal_fault), 32'(ei));
    @(posedge clk);
    // R10: only a flag-free write to a storage index commits
    if (we && wi < 22 && !e_prot(wi, 1'b1, kern) && !e_ill(wi)) m[wi] = wd;
    if (pcl) m_pc = pcn;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_a_en = 0; rd_b_en = 0; wr_en = 0; pc_load = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 22; i++) m[i] = '0;
    m_pc = '0;

    // R9: reset with user mode on the pin, judged as kernel
    repeat (2) @(posedge clk);
    @(negedge clk);
    kernel_mode = 0; rd_a_en = 1; rd_a_idx = 5'h14; rd_b_en = 1; rd_b_idx = 5'h1C;
    #1;
    chk("R9", "table read data in reset", rd_a_data, '0);
    chk("R9", "pc in reset", rd_b_data, '0);
    chk("R9", "no prot in reset", 32'(prot_fault), 0);
    @(negedge clk); rst_n = 1;

    // kernel write sweep, reads see the old contents
    for (int ix = 0; ix < 32; ix++)
      step(ix, 1, 31 - ix, 1, ix, 1, 32'hA500_0000 ^ (32'(ix) * 32'h0101_0101),
           1, 0, '0, req_of(ix));

    // read-back sweep in both modes
    for (int k = 0; k < 2; k++)
      for (int ix = 0; ix < 32; ix++)
        step(ix, 1, ix, 1, 0, 0, '0, k[0], 0, '0, req_of(ix));

    // user mode write sweep, reads paired to show tables kept
    for (int ix = 0; ix < 32; ix++)
      step(ix, 0, 20, 0, ix, 1, 32'h5A5A_0000 | 32'(ix), 0, 0, '0,
           {req_of(ix), " R10"});
    for (int ix = 0; ix < 32; ix++)
      step(ix, 1, 21, 1, 0, 0, '0, 1, 0, '0, {req_of(ix), " R10"});

    // R7: load while the write port targets the PC
    step(0, 0, 0, 0, 28, 1, 32'hDEAD_BEEF, 0, 1, 32'h0000_4000, "R7");
    step(28, 1, 28, 1, 0, 0, '0, 0, 0, '0, "R7");
    // R6: write-port attempt on the PC alone
    step(28, 1, 0, 0, 28, 1, 32'h1111_2222, 1, 0, '0, "R6");
    step(28, 1, 28, 1, 0, 0, '0, 1, 0, '0, "R6");
    step(0, 0, 0, 0, 0, 0, '0, 1, 1, 32'hCAFE_0010, "R7");
    step(28, 1, 28, 0, 0, 0, '0, 0, 0, '0, "R7");

    // R8: disabled ports raise nothing, data still follows rules
    step(23, 0, 20, 0, 23, 0, '0, 0, 0, '0, "R8");
    step(30, 0, 5, 1, 0, 0, '0, 0, 0, '0, "R8");
    // R1: write and read same index same cycle, then next cycle
    step(7, 1, 7, 1, 7, 1, 32'h7777_0007, 0, 0, '0, "R1");
    step(7, 1, 19, 1, 0, 0, '0, 0, 0, '0, "R1");
    // R3: zero index write, alone
    step(22, 0, 0, 0, 22, 1, 32'hFFFF_FFFF, 0, 0, '0, "R3");
    step(22, 1, 22, 1, 0, 0, '0, 0, 0, '0, "R3");

    // R9: reset mid-run clears everything
    idle();
    rst_n = 0;
    @(negedge clk);
    kernel_mode = 0;
    for (int ix = 0; ix < 22; ix++) begin
      rd_a_idx = 5'(ix); rd_a_en = 1; rd_b_idx = 5'h1C; rd_b_en = 1;
      #1;
      chk("R9", "register cleared", rd_a_data, '0);
      chk("R9", "pc cleared", rd_b_data, '0);
      @(negedge clk);
    end
    rst_n = 1;
    idle();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule